// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in a receive path, after the frame parser has pulled out the 48-bit destination address of an arriving frame. For each address presented with a valid strobe it decides whether the frame is kept or dropped, and it reports why. Unicast frames are kept when they match one of two programmable station addresses. Group (multicast) frames are kept when their bin in a 512-entry hash table is set. The all-ones broadcast address is always kept. A promiscuous setting keeps everything else that would otherwise be dropped.

Software programs the block through three write strobes. One loads either half of either station address. One sets or clears a single hash bin. One sets or clears the promiscuous setting. The decision comes out one clock after the strobe. It is a registered kind code, plus an accept flag that is high for every kind except reject.

Top module: `rx_da_filter`

## Requirements
- R1: `dec_valid` is high in exactly the cycle after a cycle with `da_valid` high, and low otherwise; `dec_kind` and `dec_accept` describe the address sampled with that strobe.
- R2: Kind codes are 0 reject, 1 station match, 2 hash match, 3 broadcast and 4 promiscuous. `dec_accept` is 1 for every code except 0.
- R3: An address with bit 40 clear (individual) gets kind 1 when it equals station address 0 or station address 1. Otherwise it gets kind 0 while promiscuous is off.
- R4: On `sta_wr`, `sta_sel` picks the station address. `sta_half`=0 loads `sta_wdata[31:0]` into address bits 31:0. `sta_half`=1 loads `sta_wdata[15:0]` into address bits 47:32. The other half keeps its value.
- R5: The address 48'hFFFF_FFFF_FFFF gets kind 3 whatever the hash table and station contents are.
- R6: A non-broadcast address with bit 40 set gets kind 2 when its hash bin is set, and kind 0 otherwise while promiscuous is off. The bin is found as follows. A reflected CRC-32 (polynomial 32'hEDB88320, start value all ones, no final inversion) is run over the address bits in wire order: octet bits 47:40 first, then 39:32, and so on, each octet least significant bit first. The bin is bits 31:23 of the resulting register.
- R7: On `hash_wr`, the bin `hash_wdata[8:0]` is set to `hash_wdata[9]`, and no other bin changes. Bins 0 and 511 are both reachable.
- R8: Reset clears both station addresses, every hash bin and the promiscuous setting, and holds `dec_valid` low.
- R9: When several kinds apply, the kind reported is chosen in the order broadcast, station match, hash match, promiscuous. While promiscuous is on, an address that fits no other kind gets kind 4.
- R10: `promisc_wr` loads `promisc_val` into the promiscuous setting, and that setting holds until the next such write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, bit 40 is the group bit |
| sta_wr | input | 1 | Station address half write |
| sta_sel | input | 1 | Station address select (0 or 1) |
| sta_half | input | 1 | 0 lower 32 bits, 1 upper 16 bits |
| sta_wdata | input | 32 | Station write data |
| hash_wr | input | 1 | Hash bin write |
| hash_wdata | input | 10 | Bits 8:0 bin index, bit 9 new bin value |
| promisc_wr | input | 1 | Promiscuous setting write |
| promisc_val | input | 1 | New promiscuous setting |
| dec_valid | output | 1 | Decision valid |
| dec_accept | output | 1 | Frame accepted |
| dec_kind | output | 3 | Decision kind code |

## Verification
The bench searches for group addresses that hash to bins 0 and 511. A design that dropped an index bit or got the bit order of the hash wrong would accept the wrong addresses there. A bin is set and its neighbour is checked to stay clear, which exposes writes that spill into adjacent entries. One half of a station address is rewritten and the other half is checked to survive, which catches a write that clobbers both halves. Priority is exercised by turning promiscuous on together with broadcast, station and hash hits; a design that let promiscuous win would report kind 4 for those. A second reset follows heavy programming and must forget everything.

// File: rtl/rx_da_filter.sv
module rx_da_filter #(
  parameter int ADDR_W    = 48,
  parameter int LO_W      = 32,
  parameter int HASH_BITS = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 da_valid,
  input  logic [ADDR_W-1:0]    da,
  input  logic                 sta_wr,
  input  logic                 sta_sel,
  input  logic                 sta_half,
  input  logic [LO_W-1:0]      sta_wdata,
  input  logic                 hash_wr,
  input  logic [HASH_BITS:0]   hash_wdata,
  input  logic                 promisc_wr,
  input  logic                 promisc_val,
  output logic                 dec_valid,
  output logic                 dec_accept,
  output logic [2:0]           dec_kind
);
  localparam int HI_W    = ADDR_W - LO_W;
  localparam int ENTRIES = 1 << HASH_BITS;
  localparam int GRP_BIT = ADDR_W - 8;
  localparam int OCTETS  = ADDR_W / 8;

  localparam logic [2:0] K_REJ = 3'd0, K_STA = 3'd1, K_HASH = 3'd2,
                         K_BC  = 3'd3, K_PROM = 3'd4;

  logic [LO_W-1:0]    sta_lo [2];
  logic [HI_W-1:0]    sta_hi [2];
  logic [ENTRIES-1:0] tbl;
  logic               promisc_q;

  function automatic logic [HASH_BITS-1:0] bin_of(input logic [ADDR_W-1:0] a);
    logic [31:0] c;
    logic fb;
    c = '1;
    for (int o = 0; o < OCTETS; o++)
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ a[ADDR_W-8-8*o+b];
        c  = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
    return c[31 -: HASH_BITS];
  endfunction

  wire is_bc   = &da;
  wire is_grp  = da[GRP_BIT];
  wire sta_hit = !is_grp && ((da == {sta_hi[0], sta_lo[0]}) || (da == {sta_hi[1], sta_lo[1]}));
  wire hsh_hit = is_grp && tbl[bin_of(da)];

  logic [2:0] kind_nx;
  always_comb begin
    if (is_bc)          kind_nx = K_BC;
    else if (sta_hit)   kind_nx = K_STA;
    else if (hsh_hit)   kind_nx = K_HASH;
    else if (promisc_q) kind_nx = K_PROM;
    else                kind_nx = K_REJ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_lo[0] <= '0; sta_lo[1] <= '0;
      sta_hi[0] <= '0; sta_hi[1] <= '0;
      tbl       <= '0;
      promisc_q <= 1'b0;
      dec_valid <= 1'b0;
      dec_kind  <= K_REJ;
    end else begin
      if (sta_wr) begin
        if (sta_half) sta_hi[sta_sel] <= sta_wdata[HI_W-1:0];
        else          sta_lo[sta_sel] <= sta_wdata;
      end
      if (hash_wr) tbl[hash_wdata[HASH_BITS-1:0]] <= hash_wdata[HASH_BITS];
      if (promisc_wr) promisc_q <= promisc_val;
      dec_valid <= da_valid;
      if (da_valid) dec_kind <= kind_nx;
    end
  end

  assign dec_accept = (dec_kind != K_REJ);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> dec_valid);
  a_r1_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> !dec_valid);
  a_r5_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && (&da)) |=> (dec_kind == K_BC && dec_accept));
  a_r9_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && promisc_q) |=> dec_accept);
  a_r3_unicast_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !da[GRP_BIT] && !promisc_q &&
     da != {sta_hi[0], sta_lo[0]} && da != {sta_hi[1], sta_lo[1]}) |=> !dec_accept);
  a_r7_hash_write: assert property (@(posedge clk) disable iff (!rst_n)
    hash_wr |=> tbl[$past(hash_wdata[HASH_BITS-1:0])] == $past(hash_wdata[HASH_BITS]));
  a_r4_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    (sta_wr && !sta_half) |=> ($stable(sta_hi[0]) && $stable(sta_hi[1])));
endmodule

// File: tb/rx_da_filter_test.sv
module rx_da_filter_test;
  logic clk = 0, rst_n = 0;
  logic da_valid = 0;
  logic [47:0] da = '0;
  logic sta_wr = 0, sta_sel = 0, sta_half = 0;
  logic [31:0] sta_wdata = '0;
  logic hash_wr = 0;
  logic [9:0] hash_wdata = '0;
  logic promisc_wr = 0, promisc_val = 0;
  logic dec_valid, dec_accept;
  logic [2:0] dec_kind;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_da_filter uut (.clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da),
    .sta_wr(sta_wr), .sta_sel(sta_sel), .sta_half(sta_half), .sta_wdata(sta_wdata),
    .hash_wr(hash_wr), .hash_wdata(hash_wdata), .promisc_wr(promisc_wr),
    .promisc_val(promisc_val), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_kind(dec_kind));

  function automatic logic [8:0] hbin(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic bit_in = a[40 - 8*(i/8) + (i%8)];
      logic top = r[0] ^ bit_in;
      r = r >> 1;
      if (top) r = r ^ 32'hEDB88320;
    end
    return r[31:23];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk);
    check(dec_valid == 0, "R8 valid low in reset", dec_valid, 0);
    rst_n = 1;
  endtask

  task automatic lookup(input logic [47:0] a, input int exp, input string tag);
    @(negedge clk); da_valid = 1; da = a;
    @(negedge clk); da_valid = 0; da = '0;
    check(dec_valid == 1, {tag, " R1 valid"}, dec_valid, 1);
    check(dec_kind == exp, {tag, " kind"}, dec_kind, exp);
    check(dec_accept == (exp != 0), {tag, " R2 accept"}, dec_accept, exp != 0);
    @(negedge clk);
    check(dec_valid == 0, {tag, " R1 one cycle"}, dec_valid, 0);
  endtask

  task automatic wr_sta(input bit sel, input bit half, input logic [31:0] d);
    @(negedge clk); sta_wr = 1; sta_sel = sel; sta_half = half; sta_wdata = d;
    @(negedge clk); sta_wr = 0;
  endtask

  task automatic set_sta(input bit sel, input logic [47:0] a);
    wr_sta(sel, 0, a[31:0]);
    wr_sta(sel, 1, {16'h0, a[47:32]});
  endtask

  task automatic wr_hash(input logic [8:0] idx, input bit v);
    @(negedge clk); hash_wr = 1; hash_wdata = {v, idx};
    @(negedge clk); hash_wr = 0;
  endtask

  task automatic wr_prom(input bit v);
    @(negedge clk); promisc_wr = 1; promisc_val = v;
    @(negedge clk); promisc_wr = 0;
  endtask

  function automatic logic [47:0] find_grp(input logic [8:0] want);
    for (int k = 0; k < 65536; k++) begin
      logic [47:0] c = 48'h0100_5E00_0000 + 48'(k);
      if (hbin(c) == want) return c;
    end
    return 48'h0100_5E00_0000;
  endfunction

  localparam logic [47:0] S0 = 48'h02AA_BBCC_DDEE;
  localparam logic [47:0] S1 = 48'h0A11_2233_4455;
  localparam logic [47:0] G1 = 48'h0100_5E00_0001;

  task automatic t_reset_state();
    lookup(S0, 0, "R8 unicast after reset");
    lookup(G1, 0, "R8 group after reset");
  endtask

  task automatic t_station();
    set_sta(0, S0);
    set_sta(1, S1);
    lookup(S0, 1, "R3 station0");
    lookup(S1, 1, "R3 station1");
    lookup(48'h02AA_BBCC_DDEF, 0, "R3 mismatch");
    wr_sta(0, 1, 32'h0000_02AB);
    lookup(S0, 0, "R4 old high half");
    lookup(48'h02AB_BBCC_DDEE, 1, "R4 low half kept");
    wr_sta(0, 0, 32'h1234_5678);
    lookup(48'h02AB_1234_5678, 1, "R4 high half kept");
    lookup(S1, 1, "R4 other station intact");
  endtask

  task automatic t_broadcast();
    lookup(48'hFFFF_FFFF_FFFF, 3, "R5 broadcast");
  endtask

  task automatic t_hash();
    logic [8:0] b = hbin(G1);
    logic [47:0] z, m;
    lookup(G1, 0, "R6 bin clear");
    wr_hash(b ^ 9'd1, 1);
    lookup(G1, 0, "R7 neighbour only");
    wr_hash(b, 1);
    lookup(G1, 2, "R6 bin set");
    wr_hash(b, 0);
    lookup(G1, 0, "R7 bin cleared");
    z = find_grp(9'd0);
    m = find_grp(9'd511);
    check(hbin(z) == 0 && hbin(m) == 511, "R7 search", hbin(z), 0);
    wr_hash(9'd0, 1);
    lookup(z, 2, "R7 bin 0");
    lookup(m, 0, "R7 bin 511 clear");
    wr_hash(9'd511, 1);
    lookup(m, 2, "R7 bin 511");
    wr_hash(b, 1);
  endtask

  task automatic t_priority();
    wr_prom(1);
    lookup(48'h0200_0000_0099, 4, "R10 promisc unicast");
    lookup(48'h0300_0000_0000 | find_grp(9'd7) & 48'h00FF_FFFF_FFFF, 4, "R9 promisc group");
    lookup(S1, 1, "R9 station over promisc");
    lookup(G1, 2, "R9 hash over promisc");
    lookup(48'hFFFF_FFFF_FFFF, 3, "R9 broadcast over promisc");
    wr_prom(0);
    lookup(48'h0200_0000_0099, 0, "R10 promisc off");
  endtask

  task automatic t_rereset();
    do_reset();
    lookup(S1, 0, "R8 station cleared");
    lookup(G1, 0, "R8 table cleared");
    lookup(48'h0200_0000_0099, 0, "R8 promisc cleared");
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_station();
    t_broadcast();
    t_hash();
    t_priority();
    t_rereset();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule